// File: doc/BRIEF.md
# Performance Monitor Counter Unit

This unit keeps four event counters for performance measurement. Each counter has its own small control register and advances by one on every cycle in which its event input is high and it is allowed to run. All counters share one global control register. That register can stop every counter at once, can arm an automatic freeze, and can enable an interrupt request.

A counter whose top bit is 1 is in the overflow condition. If that counter's condition-enable bit is set, the overflow can have two effects. It can freeze every counter, and that freeze stays in place until software releases it. It can also drive a level interrupt request, which is gated by an external interrupt-enable input. If the condition-enable bit is clear, the overflow has no effect.

Software reaches the counters and controls through one write port and one read port, both addressed by register number. A second, read-only group of register numbers returns the same counter values for user-level reads. The normal way to configure the unit is to set the global freeze bit, program the counters and controls, and then clear the freeze bit.

Top module: `perfMonUnit`

## Requirements
- R1: After reset every counter, every local control register and the global control register read 0, and `pmIrq` is 0.
- R2: Counter n increases by exactly 1 at each rising edge where `evtIn[n]` is 1, its run bit (local control bit 1) is 1, and no freeze is active. Under any other conditions it holds its value unless it is written.
- R3: If a counter's condition-enable bit (local control bit 0) is 0, a 1 in its top bit has no effect. The counter keeps counting and wraps from all ones to 0, no freeze occurs and `pmIrq` stays 0.
- R4: If condition-enable is 1 and the global freeze-on-condition bit (bit 1) is 1, then once that counter's top bit is 1, no counter advances on any later edge. The global freeze bit (bit 0) reads 1 from the next edge on. A write that clears bit 0 does not take effect while the triggering condition still holds.
- R5: While global bit 0 is 1, no counter advances. Once it is cleared, counting resumes.
- R6: `pmIrq` is 1 in exactly the cycles where `extIntEn` is 1, global bit 2 is 1, and at least one counter has both its top bit and its condition-enable bit set. The request is not held: it falls as soon as any of these conditions goes away.
- R7: Register numbers 0 to 3 return the values of counters 0 to 3. Writes to these numbers are ignored.
- R8: Register map. Counters are at 16 to 19 and can be read and written. Local controls are at 32 to 35 (bit 0 condition-enable, bit 1 run, all other bits read 0). Global control is at 48 (bit 0 freeze, bit 1 freeze-on-condition, bit 2 interrupt enable, all other bits read 0). `rdData` follows `rdAddr` in the same cycle.
- R9: A write to a counter takes priority over an increment of that counter in the same cycle.
- R10: A write to an unmapped register number changes nothing, and a read of one returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtIn | input | 4 | One event strobe per counter |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 6 | Register number for the write |
| wrData | input | 32 | Write data |
| rdAddr | input | 6 | Register number for the read |
| rdData | output | 32 | Read data, combinational |
| extIntEn | input | 1 | External interrupt-enable level |
| pmIrq | output | 1 | Level interrupt request |

## Verification
A wrong internal state shows up at the ports within one cycle. If the freeze latch is missed or an increment gate is wrong, a counter read a few edges after an event burst is off by one or more. A condition-enable or interrupt-enable bit that holds the wrong value makes `pmIrq` disagree with the expected level in the same cycle the inputs settle. Decode errors show up at once as nonzero reads of unmapped numbers, as writable alias numbers, or as a write that loses to a same-cycle increment.

// File: rtl/perfMonPkg.sv
package perfMonPkg;
  parameter int NUM_CNT = 4;
  parameter int CNT_W   = 32;
  parameter int ADDR_W  = 6;

  localparam int ALIAS_BASE = 0;
  localparam int CNT_BASE   = 16;
  localparam int LCTL_BASE  = 32;
  localparam int GCTL_ADDR  = 48;

  localparam int LCTL_COND = 0;
  localparam int LCTL_RUN  = 1;
  localparam int GCTL_FRZ  = 0;
  localparam int GCTL_FOC  = 1;
  localparam int GCTL_IEN  = 2;

  typedef struct packed {
    logic [NUM_CNT-1:0] load;
    logic [NUM_CNT-1:0] inc;
  } cntStrobe_t;
endpackage

// File: rtl/perfMonDatapath.sv
module perfMonDatapath
  import perfMonPkg::*;
(
  input  logic                           clk,
  input  logic                           rstN,
  input  cntStrobe_t                     strobe,
  input  logic [CNT_W-1:0]               wrData,
  output logic [NUM_CNT-1:0][CNT_W-1:0]  cntVal
);
  for (genvar g = 0; g < NUM_CNT; g++) begin : gCnt
    always_ff @(posedge clk) begin
      if (!rstN)              cntVal[g] <= '0;
      else if (strobe.load[g]) cntVal[g] <= wrData;
      else if (strobe.inc[g])  cntVal[g] <= cntVal[g] + 1'b1;
    end

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rstN)
      strobe.load[g] |=> cntVal[g] == $past(wrData)); // R9
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.inc[g] && !strobe.load[g]) |=> cntVal[g] == $past(cntVal[g]) + 1'b1); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      (!strobe.inc[g] && !strobe.load[g]) |=> $stable(cntVal[g])); // R2
  end
endmodule

// File: rtl/perfMonCtrl.sv
module perfMonCtrl
  import perfMonPkg::*;
(
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [NUM_CNT-1:0]             evtIn,
  input  logic                           wrEn,
  input  logic [ADDR_W-1:0]              wrAddr,
  input  logic [CNT_W-1:0]               wrData,
  input  logic [ADDR_W-1:0]              rdAddr,
  input  logic                           extIntEn,
  input  logic [NUM_CNT-1:0][CNT_W-1:0]  cntVal,
  output cntStrobe_t                     strobe,
  output logic [CNT_W-1:0]               rdData,
  output logic                           pmIrq
);
  logic [NUM_CNT-1:0] condEn, runEn, ovf;
  logic freezeAll, freezeOnCond, intEn, freezeTrig, gctlHit;

  always_comb begin
    for (int n = 0; n < NUM_CNT; n++) ovf[n] = cntVal[n][CNT_W-1] & condEn[n];
  end

  assign freezeTrig = freezeOnCond & (|ovf);
  assign gctlHit    = wrEn && (wrAddr == ADDR_W'(GCTL_ADDR));
  assign pmIrq      = extIntEn & intEn & (|ovf);

  always_comb begin
    for (int n = 0; n < NUM_CNT; n++) begin
      strobe.load[n] = wrEn && (wrAddr == ADDR_W'(CNT_BASE + n));
      strobe.inc[n]  = evtIn[n] & runEn[n] & ~freezeAll & ~freezeTrig;
    end
  end

  for (genvar g = 0; g < NUM_CNT; g++) begin : gLctl
    always_ff @(posedge clk) begin
      if (!rstN) begin
        condEn[g] <= 1'b0;
        runEn[g]  <= 1'b0;
      end else if (wrEn && (wrAddr == ADDR_W'(LCTL_BASE + g))) begin
        condEn[g] <= wrData[LCTL_COND];
        runEn[g]  <= wrData[LCTL_RUN];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      freezeAll    <= 1'b0;
      freezeOnCond <= 1'b0;
      intEn        <= 1'b0;
    end else if (gctlHit) begin
      freezeAll    <= wrData[GCTL_FRZ] | freezeTrig;
      freezeOnCond <= wrData[GCTL_FOC];
      intEn        <= wrData[GCTL_IEN];
    end else begin
      freezeAll    <= freezeAll | freezeTrig;
    end
  end

  always_comb begin
    rdData = '0;
    for (int n = 0; n < NUM_CNT; n++) begin
      if (rdAddr == ADDR_W'(ALIAS_BASE + n) || rdAddr == ADDR_W'(CNT_BASE + n))
        rdData = cntVal[n];
      if (rdAddr == ADDR_W'(LCTL_BASE + n)) begin
        rdData[LCTL_COND] = condEn[n];
        rdData[LCTL_RUN]  = runEn[n];
      end
    end
    if (rdAddr == ADDR_W'(GCTL_ADDR)) begin
      rdData[GCTL_FRZ] = freezeAll;
      rdData[GCTL_FOC] = freezeOnCond;
      rdData[GCTL_IEN] = intEn;
    end
  end

  AST_FREEZE_STICKS: assert property (@(posedge clk) disable iff (!rstN)
    freezeTrig |=> freezeAll); // R4
  AST_FROZEN_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (freezeAll && strobe.load == '0) |=> $stable(cntVal)); // R5
  AST_ALIAS_RO: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr < ADDR_W'(ALIAS_BASE + NUM_CNT)) |-> strobe.load == '0); // R7
endmodule

// File: rtl/perfMonUnit.sv
module perfMonUnit
  import perfMonPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_CNT-1:0]  evtIn,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [CNT_W-1:0]    wrData,
  input  logic [ADDR_W-1:0]   rdAddr,
  output logic [CNT_W-1:0]    rdData,
  input  logic                extIntEn,
  output logic                pmIrq
);
  cntStrobe_t strobe;
  logic [NUM_CNT-1:0][CNT_W-1:0] cntVal;

  perfMonCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .extIntEn(extIntEn), .cntVal(cntVal),
    .strobe(strobe), .rdData(rdData), .pmIrq(pmIrq)
  );

  perfMonDatapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData), .cntVal(cntVal)
  );
endmodule

// File: tb/perfMonUnit_tb.sv
module perfMonUnit_tb;
  logic clk = 0, rstN = 0, wrEn = 0, extIntEn = 0;
  logic [3:0] evtIn = '0;
  logic [5:0] wrAddr = '0, rdAddr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic pmIrq;
  int total = 0, bad = 0;
  bit done = 0, mBusy = 0;

  typedef struct { bit isIrq; logic [5:0] addr; logic [31:0] exp; string tag; } item_t;
  item_t sbQ[$];

  always #2.5 clk = ~clk;

  perfMonUnit u_dut (.clk(clk), .rstN(rstN), .evtIn(evtIn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .extIntEn(extIntEn), .pmIrq(pmIrq));

  // monitor: pops expected items and compares them against the ports
  initial forever begin
    @(negedge clk);
    while (sbQ.size() > 0) begin
      item_t it;
      mBusy = 1;
      it = sbQ.pop_front();
      rdAddr = it.addr;
      #1;
      total++;
      if (it.isIrq) begin
        if (pmIrq !== it.exp[0]) begin
          bad++; $display("FAIL %s: pmIrq actual=%0b expected=%0b", it.tag, pmIrq, it.exp[0]);
        end
      end else if (rdData !== it.exp) begin
        bad++; $display("FAIL %s: reg %0d actual=%h expected=%h", it.tag, it.addr, rdData, it.exp);
      end
      mBusy = 0;
    end
  end

  task automatic expReg(input logic [5:0] a, input logic [31:0] e, input string tag);
    item_t it;
    it.isIrq = 0; it.addr = a; it.exp = e; it.tag = tag;
    sbQ.push_back(it);
    wait (sbQ.size() == 0 && !mBusy);
  endtask

  task automatic expIrq(input logic e, input string tag);
    item_t it;
    it.isIrq = 1; it.addr = 0; it.exp = {31'b0, e}; it.tag = tag;
    sbQ.push_back(it);
    wait (sbQ.size() == 0 && !mBusy);
  endtask

  task automatic regWr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); wrEn = 1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic pulse(input logic [3:0] m, input int k);
    @(negedge clk); evtIn = m;
    repeat (k) @(negedge clk);
    evtIn = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run hung actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    expReg(16, 0, "R1 cnt0"); expReg(19, 0, "R1 cnt3");
    expReg(32, 0, "R1 lctl0"); expReg(48, 0, "R1 gctl"); expIrq(0, "R1 irq");
    // R8 map and field widths
    regWr(32, 32'hFFFF_FFFF); expReg(32, 3, "R8 lctl bits");
    regWr(48, 32'hFFFF_FFF9); expReg(48, 1, "R8 gctl bits");
    regWr(16, 32'h1234_5678); expReg(16, 32'h1234_5678, "R8 cnt rw");
    expReg(0, 32'h1234_5678, "R7 alias read");
    // R5 freeze-all stops counting
    regWr(16, 0);
    for (int n = 0; n < 4; n++) regWr(6'(32 + n), 2);
    pulse(4'hF, 5);
    expReg(16, 0, "R5 frozen cnt0"); expReg(18, 0, "R5 frozen cnt2");
    regWr(48, 0);
    // R2 counting with run bits
    regWr(35, 0);
    pulse(4'b1101, 3);
    expReg(16, 3, "R2 cnt0"); expReg(17, 0, "R2 cnt1 idle");
    expReg(18, 3, "R2 cnt2"); expReg(19, 0, "R2 cnt3 run off");
    // R7 alias write ignored
    regWr(1, 32'h0000_AAAA); expReg(17, 0, "R7 alias write");
    // R10 unmapped
    regWr(5, 32'hDEAD_BEEF); expReg(5, 0, "R10 read unmapped");
    expReg(63, 0, "R10 read 63"); expReg(16, 3, "R10 no side effect");
    // R9 write beats increment
    @(negedge clk); evtIn = 4'b0001; wrEn = 1; wrAddr = 16; wrData = 100;
    @(negedge clk); evtIn = '0; wrEn = 0;
    expReg(16, 100, "R9 write priority");
    // R3 condition disabled
    extIntEn = 1;
    regWr(48, 6); regWr(16, 32'h7FFF_FFFE);
    pulse(4'b0001, 3);
    expReg(16, 32'h8000_0001, "R3 counts past msb"); expIrq(0, "R3 no irq");
    expReg(48, 6, "R3 no freeze");
    regWr(16, 32'hFFFF_FFFF); pulse(4'b0001, 2);
    expReg(16, 1, "R3 wrap");
    // R6 level interrupt
    regWr(32, 3); regWr(16, 32'h8000_0000); regWr(48, 4);
    extIntEn = 0; expIrq(0, "R6 ee low");
    extIntEn = 1; expIrq(1, "R6 asserted");
    regWr(48, 0); expIrq(0, "R6 ien cleared");
    regWr(48, 4); expIrq(1, "R6 re-enabled");
    regWr(32, 2); expIrq(0, "R6 cond cleared");
    regWr(32, 3); regWr(16, 0); expIrq(0, "R6 msb gone");
    // R4 freeze on condition
    regWr(48, 2); regWr(16, 32'h7FFF_FFFE); regWr(17, 10);
    pulse(4'b0011, 5);
    expReg(16, 32'h8000_0000, "R4 cnt0 stopped"); expReg(17, 12, "R4 cnt1 stopped");
    expReg(48, 3, "R4 freeze set");
    regWr(48, 2); expReg(48, 3, "R4 clear blocked");
    regWr(16, 0); regWr(48, 2); expReg(48, 2, "R4 released");
    pulse(4'b0010, 2); expReg(17, 14, "R4 resumes");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule